// File: doc/BRIEF.md
# Supply Supervisor for Power-Up Restore

This block watches three digital flags from supply comparators (supply above the switch level, supply above the store-inhibit level, supply below the reset level) and turns them into three registered controls for a nonvolatile static memory: a store-inhibit level, a one-cycle automatic recall request for the store/recall controller, and a restore-busy level that keeps normal memory access blocked.

A recall is armed at reset and whenever the supply sinks below the reset level. It fires once the supply is back above the switch level. The restore window then lasts a fixed number of clocks from that point, and it also waits for the controller's completion pulse. A brownout that stays above the reset level only raises store-inhibit and leaves the memory contents alone. If the supply falls below the switch level while a restore is running, the restore is abandoned and the recall stays armed for the next recovery. The comparator flags are asynchronous, so they pass through a synchronizer chain first.

Top module: `nv_supply_supervisor`

## Requirements
- R1: While reset is held, and after it is released, `restore_busy` is 1, `store_inhibit` is 1 and `recall_req` is 0. A recall is armed, so memory stays blocked until a restore has run.
- R2: `store_inhibit` is 1 exactly when the synchronized `vcc_above_inhibit` flag is 0. It follows that input SYNC_STAGES+1 clock edges after the input changes.
- R3: With a recall armed and the reset-level flag clear, the synchronized `vcc_above_switch` flag at 1 makes `recall_req` high for exactly one cycle, SYNC_STAGES+1 edges after the flag rises. `restore_busy` is 1 in that cycle.
- R4: Suppose `recall_done` arrives before the restore time is up. Then `restore_busy` stays 1 for exactly RESTORE_CLKS cycles, counting the cycle in which `recall_req` is high, and is 0 in the next cycle.
- R5: Suppose `recall_done` has not arrived when the restore time is up. Then `restore_busy` stays 1 and falls at the first clock edge that samples `recall_done` high.
- R6: A dip below the switch and inhibit levels that never reaches the reset level raises `store_inhibit`. It produces no `recall_req` and no `restore_busy` on recovery.
- R7: When the synchronized `vcc_below_reset` flag is 1, `restore_busy` goes to 1 and a recall is armed. It fires on the next recovery above the switch level.
- R8: If `vcc_above_switch` falls during a restore, the restore is abandoned. `restore_busy` stays 1, the recall stays armed, and a fresh request and a full-length restore follow the next recovery.
- R9: A `recall_done` pulse outside a restore has no effect. In particular, it does not shorten the next restore.
- R10: `recall_req` is never high unless the synchronized switch flag was 1 on the edge that raised it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vcc_above_switch | input | 1 | Comparator flag: supply above the switch (recall) level, asynchronous |
| vcc_above_inhibit | input | 1 | Comparator flag: supply above the store-inhibit level, asynchronous |
| vcc_below_reset | input | 1 | Comparator flag: supply below the reset level, asynchronous |
| recall_done | input | 1 | Completion pulse from the store/recall controller |
| store_inhibit | output | 1 | Stores forbidden |
| recall_req | output | 1 | One-cycle automatic recall request |
| restore_busy | output | 1 | Normal memory access blocked |

## Verification
The bench builds the block with SYNC_STAGES=2 and RESTORE_CLKS=12. At these values the synchronizer latency is three edges and a whole restore window is only a dozen cycles. The exact edge at which the request rises and at which busy falls can therefore be checked cycle by cycle. The short window also leaves room to abort a restore partway, then hold completion back past the timer, all within one power-up, shallow-dip and deep-dip sequence.

// File: rtl/nv_supervisor_pkg.sv
package nv_supervisor_pkg;
  typedef enum logic [0:0] {
    SV_IDLE    = 1'b0,
    SV_RESTORE = 1'b1
  } sv_state_t;

  // Order of the synchronized flag vector
  localparam int FLAG_SWITCH  = 0;
  localparam int FLAG_INHIBIT = 1;
  localparam int FLAG_RESET   = 2;
  localparam int NUM_FLAGS    = 3;
endpackage

// File: rtl/nv_flag_sync.sv
module nv_flag_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[b]}};
        else     chain <= {chain[STAGES-2:0], async_in[b]};
      end
      assign sync_out[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/nv_restore_timer.sv
module nv_restore_timer #(
  parameter int LENGTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CW = (LENGTH > 1) ? $clog2(LENGTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(LENGTH - 1);

  logic [CW-1:0] cnt;

  assign expired = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear)        cnt <= '0;
    else if (run && !expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nv_supervisor_fsm.sv
module nv_supervisor_fsm
  import nv_supervisor_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sw_ok,
  input  logic inh_ok,
  input  logic vcc_low,
  input  logic done_in,
  input  logic timer_expired,
  output logic timer_clear,
  output logic timer_run,
  output logic store_inhibit,
  output logic recall_req,
  output logic restore_busy
);
  sv_state_t st;
  logic      armed;
  logic      done_seen;
  logic      start, abort, finish;

  always_comb begin
    start  = (st == SV_IDLE) && armed && sw_ok && !vcc_low;
    abort  = (st == SV_RESTORE) && (vcc_low || !sw_ok);
    finish = (st == SV_RESTORE) && !abort && timer_expired && (done_seen || done_in);
    timer_clear = start;
    timer_run   = (st == SV_RESTORE) && !abort;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= SV_IDLE;
      armed         <= 1'b1;
      done_seen     <= 1'b0;
      recall_req    <= 1'b0;
      restore_busy  <= 1'b1;
      store_inhibit <= 1'b1;
    end else begin
      recall_req    <= start;
      store_inhibit <= !inh_ok;
      unique case (st)
        SV_IDLE: begin
          if (vcc_low) begin
            armed        <= 1'b1;
            restore_busy <= 1'b1;
          end else if (start) begin
            st           <= SV_RESTORE;
            armed        <= 1'b0;
            done_seen    <= 1'b0;
            restore_busy <= 1'b1;
          end else begin
            restore_busy <= armed;
          end
        end
        SV_RESTORE: begin
          if (abort) begin
            st           <= SV_IDLE;
            armed        <= 1'b1;
            restore_busy <= 1'b1;
          end else if (finish) begin
            st           <= SV_IDLE;
            restore_busy <= 1'b0;
          end else if (done_in) begin
            done_seen    <= 1'b1;
          end
        end
        default: st <= SV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nv_supply_supervisor.sv
module nv_supply_supervisor
  import nv_supervisor_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int RESTORE_CLKS = 27500
) (
  input  logic clk,
  input  logic rst,
  input  logic vcc_above_switch,
  input  logic vcc_above_inhibit,
  input  logic vcc_below_reset,
  input  logic recall_done,
  output logic store_inhibit,
  output logic recall_req,
  output logic restore_busy
);
  // Power-off view: below every level
  localparam logic [NUM_FLAGS-1:0] FLAG_RST = NUM_FLAGS'(1) << FLAG_RESET;

  logic [NUM_FLAGS-1:0] raw_flags, sync_flags;
  logic sw_ok, inh_ok, vcc_low;
  logic t_clear, t_run, t_expired;

  always_comb begin
    raw_flags               = '0;
    raw_flags[FLAG_SWITCH]  = vcc_above_switch;
    raw_flags[FLAG_INHIBIT] = vcc_above_inhibit;
    raw_flags[FLAG_RESET]   = vcc_below_reset;
  end

  nv_flag_sync #(
    .WIDTH   (NUM_FLAGS),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (FLAG_RST)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (raw_flags),
    .sync_out (sync_flags)
  );

  assign sw_ok   = sync_flags[FLAG_SWITCH];
  assign inh_ok  = sync_flags[FLAG_INHIBIT];
  assign vcc_low = sync_flags[FLAG_RESET];

  nv_restore_timer #(
    .LENGTH (RESTORE_CLKS)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear   (t_clear),
    .run     (t_run),
    .expired (t_expired)
  );

  nv_supervisor_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .sw_ok         (sw_ok),
    .inh_ok        (inh_ok),
    .vcc_low       (vcc_low),
    .done_in       (recall_done),
    .timer_expired (t_expired),
    .timer_clear   (t_clear),
    .timer_run     (t_run),
    .store_inhibit (store_inhibit),
    .recall_req    (recall_req),
    .restore_busy  (restore_busy)
  );
endmodule

// File: rtl/nv_supply_supervisor_chk.sv
module nv_supply_supervisor_chk #(
  parameter int RESTORE_CLKS = 16
) (
  input logic clk,
  input logic rst,
  input logic sw_ok,
  input logic inh_ok,
  input logic vcc_low,
  input logic store_inhibit,
  input logic recall_req,
  input logic restore_busy
);
  localparam int CW = $clog2(RESTORE_CLKS + 2) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] since_req;
  always_ff @(posedge clk) begin
    if (rst)                   since_req <= '0;
    else if (recall_req)       since_req <= CW'(1);
    else if (since_req != CMAX) since_req <= since_req + 1'b1;
  end

  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    recall_req |=> !recall_req);

  // R3
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    recall_req |-> restore_busy);

  // R4
  busy_min_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(restore_busy) |-> (since_req >= CW'(RESTORE_CLKS)));

  // R7
  low_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    vcc_low |=> restore_busy);

  // R10
  req_needs_switch_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(recall_req) |-> $past(sw_ok));

  // R2
  inhibit_track_chk: assert property (@(posedge clk) disable iff (rst)
    !inh_ok |=> store_inhibit);
endmodule

bind nv_supply_supervisor nv_supply_supervisor_chk #(
  .RESTORE_CLKS (RESTORE_CLKS)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .sw_ok         (sw_ok),
  .inh_ok        (inh_ok),
  .vcc_low       (vcc_low),
  .store_inhibit (store_inhibit),
  .recall_req    (recall_req),
  .restore_busy  (restore_busy)
);

// File: tb/test_nv_supply_supervisor.sv
module test_nv_supply_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam int N          = 12;
  localparam int LAT        = SYNC + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw = 1'b0, inh = 1'b0, lo = 1'b1, done = 1'b0;
  logic store_inhibit, recall_req, restore_busy;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nv_supply_supervisor #(
    .SYNC_STAGES  (SYNC),
    .RESTORE_CLKS (N)
  ) i_nv_supply_supervisor (
    .clk               (clk),
    .rst               (rst),
    .vcc_above_switch  (sw),
    .vcc_above_inhibit (inh),
    .vcc_below_reset   (lo),
    .recall_done       (done),
    .store_inhibit     (store_inhibit),
    .recall_req        (recall_req),
    .restore_busy      (restore_busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Request must rise exactly LAT samples after the switch flag is driven
  task automatic await_req(input string tag);
    for (int i = 1; i <= LAT; i++) begin
      tick();
      if (i < LAT) chk(recall_req == 1'b0, tag, recall_req, 0);
      else begin
        chk(recall_req == 1'b1, tag, recall_req, 1);
        chk(restore_busy == 1'b1, tag, restore_busy, 1);
      end
    end
  endtask

  // Called at the sample where recall_req is high
  task automatic run_restore(input bit give_done, input string tag);
    int early_drop = 0, extra_req = 0;
    for (int k = 1; k < N; k++) begin
      tick();
      if (restore_busy !== 1'b1) early_drop++;
      if (recall_req !== 1'b0) extra_req++;
      if (give_done && k == 2) done = 1'b1;
      if (k == 3) done = 1'b0;
    end
    chk(early_drop == 0, {tag, " busy held"}, early_drop, 0);
    chk(extra_req == 0, "R3 single pulse", extra_req, 0);
    tick();
    if (give_done) begin
      chk(restore_busy == 1'b0, "R4 busy ends after RESTORE_CLKS", restore_busy, 0);
    end else begin
      chk(restore_busy == 1'b1, "R9 stray done ignored", restore_busy, 1);
      repeat (3) tick();
      chk(restore_busy == 1'b1, "R5 waits for done", restore_busy, 1);
      done = 1'b1;
      tick();
      chk(restore_busy == 1'b0, "R5 busy falls on done", restore_busy, 0);
      done = 1'b0;
    end
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk(recall_req == 1'b0 && restore_busy == 1'b1 && store_inhibit == 1'b1,
        "R1 reset outputs", {recall_req, restore_busy, store_inhibit}, 3);
    rst = 1'b0;
    repeat (4) tick();
    chk(restore_busy == 1'b1, "R1 busy after reset", restore_busy, 1);
    chk(recall_req == 1'b0, "R1 no req while off", recall_req, 0);
  endtask

  task automatic t_powerup();
    lo = 1'b0; inh = 1'b1;
    for (int i = 1; i <= LAT; i++) begin
      tick();
      if (i == LAT - 1) chk(store_inhibit == 1'b1, "R2 inhibit latency", store_inhibit, 1);
      if (i == LAT)     chk(store_inhibit == 1'b0, "R2 inhibit released", store_inhibit, 0);
    end
    repeat (2) tick();
    chk(restore_busy == 1'b1 && recall_req == 1'b0, "R1 armed before switch",
        restore_busy, 1);
    sw = 1'b1;
    await_req("R3 power-up req");
    run_restore(1'b1, "R4");
  endtask

  task automatic t_shallow();
    int seen_req = 0, seen_busy = 0;
    sw = 1'b0; inh = 1'b0;
    repeat (LAT) tick();
    chk(store_inhibit == 1'b1, "R2 inhibit in dip", store_inhibit, 1);
    chk(restore_busy == 1'b0, "R6 no busy in shallow dip", restore_busy, 0);
    inh = 1'b1; sw = 1'b1;
    for (int i = 0; i < 2 * LAT + N; i++) begin
      tick();
      if (recall_req) seen_req++;
      if (restore_busy) seen_busy++;
    end
    chk(seen_req == 0, "R6 no recall after shallow dip", seen_req, 0);
    chk(seen_busy == 0, "R6 no busy after shallow dip", seen_busy, 0);
    chk(store_inhibit == 1'b0, "R2 inhibit cleared", store_inhibit, 0);
  endtask

  task automatic t_deep();
    sw = 1'b0; inh = 1'b0; lo = 1'b1;
    repeat (LAT) tick();
    chk(restore_busy == 1'b1, "R7 busy on deep dip", restore_busy, 1);
    done = 1'b1;
    tick();
    done = 1'b0;
    lo = 1'b0; inh = 1'b1;
    repeat (5) tick();
    chk(restore_busy == 1'b1 && recall_req == 1'b0, "R7 wait for switch level",
        restore_busy, 1);
    sw = 1'b1;
    await_req("R7 recall after deep dip");
    run_restore(1'b0, "R9");
  endtask

  task automatic t_abort();
    int dropped = 0, reqs = 0;
    sw = 1'b0; inh = 1'b0; lo = 1'b1;
    repeat (LAT) tick();
    lo = 1'b0; inh = 1'b1; sw = 1'b1;
    await_req("R8 first req");
    repeat (3) tick();
    sw = 1'b0;
    for (int i = 0; i < LAT + N + 2; i++) begin
      tick();
      if (restore_busy !== 1'b1) dropped++;
      if (recall_req) reqs++;
    end
    chk(dropped == 0, "R8 busy held through abort", dropped, 0);
    chk(reqs == 0, "R8 no req while low", reqs, 0);
    sw = 1'b1;
    await_req("R8 re-armed req");
    run_restore(1'b1, "R8");
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_shallow();
    t_deep();
    t_abort();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule